// File: doc/BRIEF.md
# Packed Lane Shift Unit

This block shifts a 64-bit operand as a set of independent lanes. Each lane is 8, 16, 32 or 64 bits wide. It offers three shifts: logical left, logical right and arithmetic right. No bit ever moves from one lane into its neighbour. The shift count comes either from a full 64-bit register operand or from an 8-bit immediate, and one select input picks between them.

Byte lanes are built from the word-lane shifter. The word result is ANDed with a mask that is generated in logic from the direction and the count, so no mask table is stored. A count at or above the lane width has a saturated result. A logical shift then gives zero, and an arithmetic shift gives copies of the sign bit.

The result is registered. A valid strobe rises one cycle after each accepted request.

Top module: `packed_shift_unit`

## Requirements
- R1: While reset is active, and after it is released with no request given, `outValid` is 0 and `dataOut` is all zeros.
- R2: A request with `inValid`=1 gives `outValid`=1 and the new `dataOut` at the next rising edge. In a cycle with `inValid`=0, `outValid` falls to 0 and `dataOut` keeps its last value, whatever the other inputs are doing.
- R3: `laneSize` selects the lane width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Every lane is shifted independently, and no bit crosses a lane edge.
- R4: `shiftOp`=0 is a logical left shift. Vacated low bits are filled with zeros, and bits moved past the lane's top edge are discarded.
- R5: `shiftOp`=1 is a logical right shift with zero fill. For example, the 16-bit lane 0x084C shifted right by 5 gives 0x0042.
- R6: `shiftOp`=2 is an arithmetic right shift for 16-bit and 32-bit lanes. Vacated high bits are filled with the lane's sign bit. For example, the 16-bit lane 0xFC00 shifted right by 5 gives 0xFFE0.
- R7: With `useImm`=1 the count is `immCount`, zero-extended. With `useImm`=0 the count is the full 64-bit `regCount`. The operand that is not selected has no effect.
- R8: A count greater than or equal to the lane width gives all zeros for a logical shift. For an arithmetic shift it gives a lane filled with its sign bit.
- R9: A byte-lane shift by n clears the n vacated bits at the shifted-from end of every byte. For example, a right shift by 3 leaves the top 3 bits of every byte at 0.
- R10: These requests are not supported: `shiftOp`=3, and `shiftOp`=2 with 8-bit or 64-bit lanes. Each one still gives `outValid`=1 and produces an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe |
| dataIn | input | 64 | Operand to shift |
| regCount | input | 64 | Shift count taken from a register |
| immCount | input | 8 | Shift count taken from an immediate |
| useImm | input | 1 | 1 selects immCount, 0 selects regCount |
| shiftOp | input | 2 | 0 left logical, 1 right logical, 2 right arithmetic, 3 unsupported |
| laneSize | input | 2 | 0 byte, 1 word, 2 doubleword, 3 quadword |
| outValid | output | 1 | Result strobe, one cycle after the request |
| dataOut | output | 64 | Registered shifted result |

## Verification
The assertions check on every cycle:
- the one-cycle valid latency;
- that the result holds between requests;
- the zero result of unsupported requests;
- the count clamp;
- that byte-lane shifts never leave a set bit at a byte's vacated end.

The actual lane values can only be shown by the bench scenarios. These are the sign fill, the saturation at large counts, the choice between the register and immediate counts, and lane isolation across all four sizes. The bench compares each of them against a per-element reference model.

// File: rtl/psu_pkg.sv
package psu_pkg;
  localparam int DATA_W = 64;
  localparam int CNT_W  = $clog2(DATA_W) + 1;

  typedef enum logic [1:0] {
    LANE_B = 2'd0,
    LANE_W = 2'd1,
    LANE_D = 2'd2,
    LANE_Q = 2'd3
  } lane_e;

  typedef enum logic [1:0] {
    OP_SLL = 2'd0,
    OP_SRL = 2'd1,
    OP_SRA = 2'd2,
    OP_BAD = 2'd3
  } shop_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             left;
    logic             arith;
    logic             illegal;
    lane_e            size;
    logic [CNT_W-1:0] count;
  } psu_strobe_t;
endpackage

// File: rtl/psu_ctrl.sv
module psu_ctrl
  import psu_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int IMMW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [DW-1:0]   regCount,
  input  logic [IMMW-1:0] immCount,
  input  logic            useImm,
  input  logic [1:0]      shiftOp,
  input  logic [1:0]      laneSize,
  output psu_strobe_t     sb
);
  localparam int CW = $clog2(DW) + 1;

  lane_e         size;
  shop_e         op;
  logic [DW-1:0] rawCount;
  logic [DW-1:0] laneWidth;

  assign size      = lane_e'(laneSize);
  assign op        = shop_e'(shiftOp);
  assign rawCount  = useImm ? DW'(immCount) : regCount;
  assign laneWidth = DW'(8) << size;

  always_comb begin
    sb.load    = inValid;
    sb.left    = (op == OP_SLL);
    sb.arith   = (op == OP_SRA);
    sb.illegal = (op == OP_BAD) ||
                 ((op == OP_SRA) && ((size == LANE_B) || (size == LANE_Q)));
    sb.size    = size;
    sb.count   = (rawCount >= laneWidth) ? CW'(laneWidth) : CW'(rawCount);
  end

  // R8
  cnt_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    sb.load |-> (DW'(sb.count) <= (DW'(8) << sb.size)));

  // R7
  imm_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && useImm && (immCount < IMMW'(8))) |-> (sb.count == CW'(immCount)));
endmodule

// File: rtl/psu_datapath.sv
module psu_datapath
  import psu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  psu_strobe_t   sb,
  input  logic [DW-1:0] dataIn,
  output logic          outValid,
  output logic [DW-1:0] dataOut
);
  localparam int NW = DW / 16;
  localparam int ND = DW / 32;
  localparam int NB = DW / 8;

  logic [DW-1:0] wordRes;
  logic [DW-1:0] dwordRes;
  logic [DW-1:0] qwordRes;
  logic [DW-1:0] byteMask;
  logic [DW-1:0] nextRes;
  logic [7:0]    laneMask;

  for (genvar gi = 0; gi < NW; gi++) begin : g_word
    logic [15:0] elem;
    assign elem = dataIn[gi*16 +: 16];
    assign wordRes[gi*16 +: 16] =
      sb.left  ? 16'(elem << sb.count) :
      sb.arith ? 16'($signed(elem) >>> sb.count) :
                 16'(elem >> sb.count);
  end

  for (genvar gi = 0; gi < ND; gi++) begin : g_dword
    logic [31:0] elem;
    assign elem = dataIn[gi*32 +: 32];
    assign dwordRes[gi*32 +: 32] =
      sb.left  ? 32'(elem << sb.count) :
      sb.arith ? 32'($signed(elem) >>> sb.count) :
                 32'(elem >> sb.count);
  end

  assign qwordRes = sb.left ? (dataIn << sb.count) : (dataIn >> sb.count);

  // Byte boundary mask computed from direction and count
  assign laneMask = sb.left ? 8'(8'hFF << sb.count) : 8'(8'hFF >> sb.count);
  assign byteMask = {NB{laneMask}};

  always_comb begin
    if (sb.illegal) nextRes = '0;
    else begin
      unique case (sb.size)
        LANE_B:  nextRes = wordRes & byteMask;
        LANE_W:  nextRes = wordRes;
        LANE_D:  nextRes = dwordRes;
        default: nextRes = qwordRes;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      dataOut  <= '0;
    end else begin
      outValid <= sb.load;
      if (sb.load) dataOut <= nextRes;
    end
  end

  // R2
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sb.load) |-> $stable(dataOut));

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(sb.load));

  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(sb.load && sb.illegal) |-> (dataOut == '0));

  // R9
  byte_right_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(sb.load && !sb.illegal && (sb.size == LANE_B) && !sb.left && (sb.count != '0))
      |-> ((dataOut & {NB{8'h80}}) == '0));

  // R9
  byte_left_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(sb.load && !sb.illegal && (sb.size == LANE_B) && sb.left && (sb.count != '0))
      |-> ((dataOut & {NB{8'h01}}) == '0));
endmodule

// File: rtl/packed_shift_unit.sv
module packed_shift_unit
  import psu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] dataIn,
  input  logic [63:0] regCount,
  input  logic [7:0]  immCount,
  input  logic        useImm,
  input  logic [1:0]  shiftOp,
  input  logic [1:0]  laneSize,
  output logic        outValid,
  output logic [63:0] dataOut
);
  psu_strobe_t sb;

  psu_ctrl #(.DW(64), .IMMW(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .regCount(regCount),
    .immCount(immCount), .useImm(useImm), .shiftOp(shiftOp),
    .laneSize(laneSize), .sb(sb)
  );

  psu_datapath #(.DW(64)) u_dp (
    .clk(clk), .rstN(rstN), .sb(sb), .dataIn(dataIn),
    .outValid(outValid), .dataOut(dataOut)
  );
endmodule

// File: tb/tb_packed_shift_unit.sv
module tb_packed_shift_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] dataIn = '0;
  logic [63:0] regCount = '0;
  logic [7:0]  immCount = '0;
  logic        useImm = 1'b0;
  logic [1:0]  shiftOp = '0;
  logic [1:0]  laneSize = '0;
  logic        outValid;
  logic [63:0] dataOut;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  packed_shift_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dataIn(dataIn),
    .regCount(regCount), .immCount(immCount), .useImm(useImm),
    .shiftOp(shiftOp), .laneSize(laneSize), .outValid(outValid),
    .dataOut(dataOut)
  );

  function automatic logic [63:0] refShift(logic [63:0] d, logic [63:0] cnt,
                                           logic [1:0] op, logic [1:0] size);
    logic [63:0] res, mask, e, r;
    logic sgn;
    int w;
    res = '0;
    if (op == 2'd3 || (op == 2'd2 && (size == 2'd0 || size == 2'd3))) return '0;
    w = 8 << size;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int k = 0; k < 64 / w; k++) begin
      e = (d >> (k * w)) & mask;
      sgn = e[w-1];
      if (cnt >= 64'(w)) r = (op == 2'd2 && sgn) ? mask : '0;
      else if (op == 2'd0) r = (e << cnt) & mask;
      else if (op == 2'd1) r = e >> cnt;
      else r = (e >> cnt) | (sgn ? (mask & ~(mask >> cnt)) : 64'd0);
      res = res | (r << (k * w));
    end
    return res;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic runOp(string req, logic [63:0] d, logic [63:0] rc, logic [7:0] ic,
                       logic ui, logic [1:0] op, logic [1:0] sz, logic [63:0] exp);
    @(negedge clk);
    dataIn = d; regCount = rc; immCount = ic; useImm = ui;
    shiftOp = op; laneSize = sz; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, 64'(outValid), 64'd1);
    check(req, dataOut, exp);
  endtask

  initial begin
    #500us;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d, rc, held;
    logic [7:0]  ic;
    logic        ui;
    logic [1:0]  op, sz;
    void'($urandom(32'h5EED));
    #12;
    check("R1 reset valid", 64'(outValid), 64'd0);
    check("R1 reset data", dataOut, 64'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 idle data", dataOut, 64'd0);

    runOp("R5 srl word", 64'h0000_0000_0000_084C, 64'd5, 8'd0, 1'b0, 2'd1, 2'd1, 64'h0000_0000_0000_0042);
    runOp("R6 sra word", 64'h0000_0000_0000_FC00, 64'd5, 8'd0, 1'b0, 2'd2, 2'd1, 64'h0000_0000_0000_FFE0);
    runOp("R9 byte srl3", 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 8'd0, 1'b0, 2'd1, 2'd0, 64'h1F1F_1F1F_1F1F_1F1F);
    runOp("R9 byte sll3", 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'd3, 1'b1, 2'd0, 2'd0, 64'hF8F8_F8F8_F8F8_F8F8);
    runOp("R4 word sll", 64'h8001_8001_8001_8001, 64'd1, 8'd0, 1'b0, 2'd0, 2'd1, 64'h0002_0002_0002_0002);
    runOp("R3 dword srl", 64'h0000_0001_8000_0000, 64'd4, 8'd0, 1'b0, 2'd1, 2'd2, 64'h0000_0000_0800_0000);
    runOp("R3 qword sll", 64'h0000_0000_0000_0001, 64'd63, 8'd0, 1'b0, 2'd0, 2'd3, 64'h8000_0000_0000_0000);
    runOp("R7 imm used", 64'h0000_0000_0000_00F0, 64'hFFFF, 8'd4, 1'b1, 2'd1, 2'd1, 64'h0000_0000_0000_000F);
    runOp("R7 reg used", 64'h0000_0000_0000_00F0, 64'd2, 8'd100, 1'b0, 2'd1, 2'd1, 64'h0000_0000_0000_003C);
    runOp("R8 big reg logical", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 8'd0, 1'b0, 2'd1, 2'd3, 64'd0);
    runOp("R8 sra dword sat", 64'h8000_0000_7FFF_FFFF, 64'd40, 8'd0, 1'b0, 2'd2, 2'd2, 64'hFFFF_FFFF_0000_0000);
    runOp("R8 byte count8", 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'd8, 1'b1, 2'd0, 2'd0, 64'd0);
    runOp("R8 word count16", 64'h1234_5678_9ABC_DEF0, 64'd16, 8'd0, 1'b0, 2'd0, 2'd1, 64'd0);
    runOp("R10 op3", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 1'b0, 2'd3, 2'd1, 64'd0);
    runOp("R10 sra byte", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 1'b0, 2'd2, 2'd0, 64'd0);
    runOp("R10 sra qword", 64'h8000_0000_0000_0000, 64'd1, 8'd0, 1'b0, 2'd2, 2'd3, 64'd0);

    runOp("R2 setup", 64'h1111_2222_3333_4444, 64'd0, 8'd0, 1'b0, 2'd0, 2'd1, 64'h1111_2222_3333_4444);
    held = dataOut;
    dataIn = '1; regCount = 64'd3; shiftOp = 2'd1;
    @(negedge clk);
    check("R2 hold valid", 64'(outValid), 64'd0);
    check("R2 hold data", dataOut, held);

    for (int i = 0; i < 400; i++) begin
      d  = {$urandom, $urandom};
      ui = 1'($urandom);
      ic = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 20);
      rc = ($urandom % 5 == 0) ? {$urandom, $urandom} : 64'($urandom % 70);
      op = 2'($urandom);
      sz = 2'($urandom);
      runOp("R3 random", d, rc, ic, ui, op, sz, refShift(d, ui ? 64'(ic) : rc, op, sz));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule